// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block turns stereo pairs of 24-bit two's-complement samples into one serial data line. The line is framed by a word-select clock and shifted by a bit clock. Both clocks arrive as inputs that are synchronous to the system clock `clk`. They may come from a local clock generator or from an external master; the block never drives them. The block detects each falling edge of the bit clock and, in the same `clk` cycle, updates the data line. The data line therefore settles well before the next rising edge, where the receiver samples it.

A static format input picks one of two framings:
- **Left-justified:** the most significant bit sits in the first bit slot after a word-select transition, and the left channel goes out while word select is high.
- **I2S:** the whole stream is delayed by one bit slot, and the left channel goes out while word select is low.

Half-frames of 24 or 32 bit slots (48- or 64-slot frames) are both handled without configuration, because the slot count restarts at every word-select transition.

Producers hand over a left/right pair through a valid/ready handshake into a one-entry holding register. At the start of every left half-frame the pending pair becomes the active pair. If nothing is pending, the previous pair is sent again and an underrun flag is raised.

A four-state controller sequences the block:
- `ST_IDLE`: out of reset. The first bit-clock fall captures a word-select reference and moves to `ST_SYNC`.
- `ST_SYNC`: waits for the first word-select transition, then moves to `ST_LEFT` or `ST_RIGHT` according to the channel that transition opens.
- `ST_LEFT` and `ST_RIGHT`: each word-select transition moves the controller to the other one.

The controller only changes state on a bit-clock fall.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset `ser_data` is 0, `pair_ready` is 1 and `underrun` is 0.
- R2: `ser_data` changes only in the `clk` cycle in which a falling bit-clock edge is detected. It holds its value while the bit clock is high.
- R3: Each channel word is sent most significant bit first, bit 23 down to bit 0, one bit per bit-clock slot.
- R4: With `fmt_lj`=1 (left-justified), bit 23 is on the line in slot 0, the first slot after the word-select transition. The left word is sent while `wsel_in` is 1 and the right word while it is 0.
- R5: With `fmt_lj`=0 (I2S), bit 23 is on the line in slot 1, one slot after the transition. The left word is sent while `wsel_in` is 0 and the right word while it is 1.
- R6: Slots after the 24 data bits of a half-frame carry 0. These are slots 24..31 in left-justified mode, and slots 25..31 plus the next slot 0 in I2S mode, for 32-slot half-frames.
- R7: In I2S mode with 24-slot half-frames, bit 0 of each word is sent in slot 0 of the following half-frame.
- R8: `pair_ready` drops in the cycle after a pair is accepted and stays low until the pair is loaded. A `pair_valid` pulse while `pair_ready` is 0 has no effect on the data sent.
- R9: The pending pair is loaded at the start of a left half-frame, with `underrun` cleared. If none is pending, the previous pair is repeated and `underrun` is 1 until the next left start that finds a pair.
- R10: Until the first word-select transition after reset, `ser_data` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_lj | input | 1 | 1 = left-justified framing, 0 = I2S framing (static) |
| bclk_in | input | 1 | Bit clock, synchronous to `clk` |
| wsel_in | input | 1 | Word-select (channel) clock, changes with bit-clock falls |
| pair_valid | input | 1 | Producer offers a sample pair |
| pair_ready | output | 1 | Holding register is empty |
| pair_left | input | 24 | Left sample, two's complement |
| pair_right | input | 24 | Right sample, two's complement |
| ser_data | output | 1 | Serial data line |
| underrun | output | 1 | Last left start found no pending pair |

## Verification
Every result follows a detected bit-clock fall by exactly one `clk` edge: `ser_data`, the slot position and `underrun` all update at the first rising `clk` edge that sees the bit clock low. The bench lowers the bit clock on a falling `clk` edge and reads `ser_data` one full `clk` period later, still inside the low phase. It reads it again a cycle into the high phase to confirm the value held. `underrun` is read together with slot 0 of each left half-frame. `pair_ready` is read on the falling `clk` edge after the handshake edge. The bench sweeps both framings with both half-frame lengths and a range of computed sample patterns.

// File: rtl/aser_pkg.sv
package aser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } aser_state_t;
endpackage

// File: rtl/aser_edge.sv
module aser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic wsel_in,
    output logic fall,
    output logic ws_chg
);
    logic bclk_q;
    logic ws_ref;

    assign fall   = bclk_q & ~bclk_in;
    assign ws_chg = fall & (wsel_in != ws_ref);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b1;
            ws_ref <= 1'b0;
        end else begin
            bclk_q <= bclk_in;
            if (fall) ws_ref <= wsel_in;
        end
    end
endmodule

// File: rtl/aser_hold.sv
module aser_hold #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_l,
    input  logic [WORD_W-1:0] in_r,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] out_l,
    output logic [WORD_W-1:0] out_r
);
    assign in_ready = ~full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full  <= 1'b0;
            out_l <= '0;
            out_r <= '0;
        end else if (in_valid && !full) begin
            full  <= 1'b1;
            out_l <= in_l;
            out_r <= in_r;
        end else if (take) begin
            full  <= 1'b0;
        end
    end

    // R8
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/aser_bitsel.sv
module aser_bitsel #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 5
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SLOT_W-1:0] slot,
    output logic              bit_out
);
    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = word << slot;
        bit_out = shifted[WORD_W-1];
    end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import aser_pkg::*;
#(
    parameter int WORD_W    = 24,
    parameter int MAX_SLOTS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_lj,
    input  logic              bclk_in,
    input  logic              wsel_in,
    input  logic              pair_valid,
    output logic              pair_ready,
    input  logic [WORD_W-1:0] pair_left,
    input  logic [WORD_W-1:0] pair_right,
    output logic              ser_data,
    output logic              underrun
);
    localparam int SLOT_W = $clog2(MAX_SLOTS);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(MAX_SLOTS - 1);
    localparam logic [SLOT_W-1:0] DATA_LAST = SLOT_W'(WORD_W - 1);

    aser_state_t state, nstate;
    logic              fall, ws_chg, new_left, left_start, load;
    logic              hold_full, frame_on, sel_bit, lj_bit, lj_prev, sdata_nxt;
    logic [WORD_W-1:0] hold_l, hold_r, act_l, act_r, word_sel;
    logic [SLOT_W-1:0] slot, slot_nxt;

    aser_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .bclk_in(bclk_in),
        .wsel_in(wsel_in),
        .fall   (fall),
        .ws_chg (ws_chg)
    );

    aser_hold #(.WORD_W(WORD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(pair_valid),
        .in_ready(pair_ready),
        .in_l    (pair_left),
        .in_r    (pair_right),
        .take    (load),
        .full    (hold_full),
        .out_l   (hold_l),
        .out_r   (hold_r)
    );

    // channel opened by the current word-select level
    assign new_left   = fmt_lj ? wsel_in : ~wsel_in;
    assign left_start = ws_chg && (state != ST_IDLE) && new_left;
    assign load       = left_start && hold_full;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (fall)   nstate = ST_SYNC;
            ST_SYNC:  if (ws_chg) nstate = new_left ? ST_LEFT : ST_RIGHT;
            ST_LEFT:  if (ws_chg) nstate = ST_RIGHT;
            ST_RIGHT: if (ws_chg) nstate = ST_LEFT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        if (ws_chg)                slot_nxt = '0;
        else if (slot == SLOT_LAST) slot_nxt = slot;
        else                       slot_nxt = slot + 1'b1;
        frame_on = (nstate == ST_LEFT) || (nstate == ST_RIGHT);
        if (nstate == ST_LEFT) word_sel = load ? hold_l : act_l;
        else                   word_sel = act_r;
    end

    aser_bitsel #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_bitsel (
        .word   (word_sel),
        .slot   (slot_nxt),
        .bit_out(sel_bit)
    );

    assign lj_bit    = frame_on & sel_bit;
    assign sdata_nxt = fmt_lj ? lj_bit : lj_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot     <= '0;
            act_l    <= '0;
            act_r    <= '0;
            lj_prev  <= 1'b0;
            ser_data <= 1'b0;
            underrun <= 1'b0;
        end else if (fall) begin
            slot     <= slot_nxt;
            lj_prev  <= lj_bit;
            ser_data <= sdata_nxt;
            if (load) begin
                act_l <= hold_l;
                act_r <= hold_r;
            end
            if (left_start) underrun <= ~hold_full;
        end
    end

    // R2
    ser_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(ser_data));

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(state));

    // R6
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && fmt_lj && !ws_chg && slot >= DATA_LAST) |=> !ser_data);

    // R9
    urun_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(left_start));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SYNC) |-> !ser_data);
endmodule

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_lj = 1'b1;
    logic        bclk_in = 1'b1;
    logic        wsel_in = 1'b0;
    logic        pair_valid = 1'b0;
    logic [23:0] pair_left = '0;
    logic [23:0] pair_right = '0;
    logic        pair_ready, ser_data, underrun;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    audio_ser_tx u_audio_ser_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_lj    (fmt_lj),
        .bclk_in   (bclk_in),
        .wsel_in   (wsel_in),
        .pair_valid(pair_valid),
        .pair_ready(pair_ready),
        .pair_left (pair_left),
        .pair_right(pair_right),
        .ser_data  (ser_data),
        .underrun  (underrun)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic lj_of(input logic [23:0] w, input int s);
        return (s < 24) ? w[23 - s] : 1'b0;
    endfunction

    function automatic logic [23:0] pat(input int i);
        logic [23:0] v;
        v = 24'(i * 32'h3A5C71) ^ (24'h800000 >> (i % 24));
        return v;
    endfunction

    // one bit slot: fall, read one clk later, re-read during the high phase
    task automatic slot(input logic ws, output logic got);
        @(negedge clk); bclk_in = 1'b0; wsel_in = ws;
        @(negedge clk); got = ser_data; bclk_in = 1'b1;
        @(negedge clk); check("R2", ser_data, got);
    endtask

    logic prev_last;
    logic [23:0] last_l, last_r;

    task automatic half(input int n, input logic ws, input logic [23:0] w, input logic chk_ur, input logic exp_ur);
        logic got, exp;
        string tag;
        for (int s = 0; s < n; s++) begin
            slot(ws, got);
            if (fmt_lj) begin
                exp = lj_of(w, s);
                tag = (s == 0) ? "R4" : ((s < 24) ? "R3" : "R6");
            end else begin
                exp = (s == 0) ? prev_last : lj_of(w, s - 1);
                tag = (s == 0) ? ((n == 24) ? "R7" : "R6") : ((s == 1) ? "R5" : ((s < 25) ? "R3" : "R6"));
            end
            check(tag, got, exp);
            if (s == 0 && chk_ur) check("R9", underrun, exp_ur);
        end
        prev_last = lj_of(w, n - 1);
    endtask

    task automatic frame(input int n, input logic exp_ur);
        logic lws;
        lws = fmt_lj ? 1'b1 : 1'b0;
        half(n, lws, last_l, 1'b1, exp_ur);
        half(n, ~lws, last_r, 1'b0, 1'b0);
    endtask

    task automatic push(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk); pair_valid = 1'b1; pair_left = l; pair_right = r;
        @(negedge clk); pair_valid = 1'b0;
        check("R8", pair_ready, 1'b0);
        last_l = l; last_r = r;
    endtask

    task automatic run(input logic lj, input int n);
        logic got;
        fmt_lj = lj; rst_n = 1'b0; bclk_in = 1'b1; wsel_in = lj ? 1'b0 : 1'b1;
        repeat (3) @(negedge clk);
        check("R1", ser_data, 1'b0);
        check("R1", pair_ready, 1'b1);
        check("R1", underrun, 1'b0);
        rst_n = 1'b1;
        prev_last = 1'b0; last_l = '0; last_r = '0;
        // preamble in the right-channel level: no transition yet
        for (int s = 0; s < n; s++) begin
            slot(lj ? 1'b0 : 1'b1, got);
            check("R10", got, 1'b0);
        end
        frame(n, 1'b1);
        push(24'h800001, 24'h7FFFFF);
        // ignored offer while the holding register is full
        @(negedge clk); pair_valid = 1'b1; pair_left = 24'h0F0F0F; pair_right = 24'hF0F0F0;
        @(negedge clk); pair_valid = 1'b0;
        check("R8", pair_ready, 1'b0);
        frame(n, 1'b0);
        check("R8", pair_ready, 1'b1);
        for (int k = 0; k < 4; k++) begin
            push(pat(2 * k + n), pat(2 * k + 1 + n));
            frame(n, 1'b0);
        end
        frame(n, 1'b1);
        push(24'hA5A5A5, 24'h5A5A5A);
        frame(n, 1'b0);
    endtask

    initial begin
        run(1'b1, 32);
        run(1'b1, 24);
        run(1'b0, 32);
        run(1'b0, 24);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog got=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule